// File: doc/BRIEF.md
# Saturating multiply-accumulate unit

This block is a 64-bit multiply-accumulate engine whose accumulator is kept as two 32-bit halves, an upper and a lower word. A single strobe starts one operation per cycle. Two operand words arrive on ports already fetched, and a four-bit operation code selects the work to do. The operations are narrow 16x16 and 32x32 multiplies that replace only the lower word, wide signed and unsigned 32x32 multiplies that replace the whole accumulator, two signed accumulate forms, a clear, and a load of either half. The accumulator halves are visible on two output words at all times.

The two accumulate forms saturate differently when the saturate input is high. The 16-bit form treats the lower word as a signed 32-bit total. On overflow it pins that word to the nearest 32-bit limit and writes 1 into the upper word as an overflow marker. The 32-bit form clamps the full 64-bit total to the signed 48-bit range. Each started operation updates the accumulator at the next rising edge, and a one-cycle completion pulse is raised at that same edge.

Top module: `sat_mac64`

## Requirements
- R1: While `rst` is high at a rising edge, both accumulator halves become zero and `done_o` becomes 0.
- R2: `done_o` is high for exactly the cycle after each cycle in which `start_i` is high. In any cycle without `start_i`, the accumulator keeps its value.
- R3: Code 0 writes the low 32 bits of `opa_i*opb_i` into the lower word and leaves the upper word unchanged.
- R4: Code 1 multiplies the zero-extended low 16 bits of each operand, and code 2 multiplies the sign-extended low 16 bits. Both write the 32-bit product into the lower word only, and the upper 16 bits of the operands have no effect.
- R5: Code 3 writes the unsigned 64-bit product of the two operands into the accumulator, and code 4 writes the signed 64-bit product.
- R6: Code 5 with `sat_i`=0 adds the signed 16x16 product of the low halfwords, sign-extended to 64 bits, to the whole accumulator, modulo 2^64.
- R7: Code 5 with `sat_i`=1 adds that product to the lower word read as signed. A total above 0x7FFFFFFF gives upper=1 and lower=0x7FFFFFFF. A total below -2^31 gives upper=1 and lower=0x80000000. Otherwise only the lower word takes the total and the upper word is unchanged.
- R8: Code 6 with `sat_i`=0 adds the signed 64-bit product of the two operands to the accumulator, modulo 2^64.
- R9: Code 6 with `sat_i`=1 forms the exact sum of the signed accumulator and the signed product, then clamps it to the range 0xFFFF800000000000 to 0x00007FFFFFFFFFFF.
- R10: Code 7 zeroes all 64 accumulator bits.
- R11: Code 8 loads `opa_i` into the upper word and code 9 loads it into the lower word. In each case the other word is unchanged.
- R12: Codes 10 to 15 leave the accumulator unchanged but still produce the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts the operation selected by `op_i` |
| op_i | input | 4 | Operation code (see R3 to R12) |
| sat_i | input | 1 | Saturation select for codes 5 and 6 |
| opa_i | input | 32 | First operand, also the load value |
| opb_i | input | 32 | Second operand |
| done_o | output | 1 | One-cycle completion pulse |
| acc_hi_o | output | 32 | Upper accumulator word |
| acc_lo_o | output | 32 | Lower accumulator word |

## Verification
The properties assume that `op_i`, `sat_i` and `opa_i` hold known values in every cycle where `start_i` is high, and that `rst` is only sampled on clock edges. The bench changes all inputs on falling edges and raises `start_i` for a single cycle per operation, so the code and operands are stable around the sampling edge. Operands are drawn from corner-value tables and from a deterministic shift-register generator. The accumulator is also preloaded close to both the 32-bit and the 48-bit limits before the saturating forms run, so every clamp branch is reached from both directions.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

    typedef enum logic [3:0] {
        OP_MUL_LO  = 4'd0,
        OP_MULU_N  = 4'd1,
        OP_MULS_N  = 4'd2,
        OP_MULU_W  = 4'd3,
        OP_MULS_W  = 4'd4,
        OP_MAC_N   = 4'd5,
        OP_MAC_W   = 4'd6,
        OP_CLEAR   = 4'd7,
        OP_LOAD_HI = 4'd8,
        OP_LOAD_LO = 4'd9
    } mac_op_e;

    // How the operand extender shapes each raw operand
    typedef struct packed {
        logic narrow;
        logic signed_ops;
    } opnd_mode_t;

    // What the accumulator update does with the product or load value
    typedef enum logic [2:0] {
        WR_NONE,
        WR_LO_PROD,
        WR_FULL_PROD,
        WR_ACC_N,
        WR_ACC_W,
        WR_CLEAR,
        WR_HI_LOAD,
        WR_LO_LOAD
    } wr_kind_e;

    typedef struct packed {
        opnd_mode_t mode;
        wr_kind_e   kind;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input logic [3:0] code);
        op_ctrl_t c;
        c.mode.narrow     = 1'b0;
        c.mode.signed_ops = 1'b0;
        c.kind            = WR_NONE;
        case (code)
            OP_MUL_LO:  c.kind = WR_LO_PROD;
            OP_MULU_N: begin
                c.mode.narrow = 1'b1;
                c.kind        = WR_LO_PROD;
            end
            OP_MULS_N: begin
                c.mode.narrow     = 1'b1;
                c.mode.signed_ops = 1'b1;
                c.kind            = WR_LO_PROD;
            end
            OP_MULU_W:  c.kind = WR_FULL_PROD;
            OP_MULS_W: begin
                c.mode.signed_ops = 1'b1;
                c.kind            = WR_FULL_PROD;
            end
            OP_MAC_N: begin
                c.mode.narrow     = 1'b1;
                c.mode.signed_ops = 1'b1;
                c.kind            = WR_ACC_N;
            end
            OP_MAC_W: begin
                c.mode.signed_ops = 1'b1;
                c.kind            = WR_ACC_W;
            end
            OP_CLEAR:   c.kind = WR_CLEAR;
            OP_LOAD_HI: c.kind = WR_HI_LOAD;
            OP_LOAD_LO: c.kind = WR_LO_LOAD;
            default:    c.kind = WR_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sat_mac_operand.sv
module sat_mac_operand
    import sat_mac_pkg::*;
#(
    parameter int IN_W     = 32,
    parameter int NARROW_W = 16,
    parameter int EXT_W    = 33
) (
    input  logic [IN_W-1:0]         raw_i,
    input  opnd_mode_t              mode_i,
    output logic signed [EXT_W-1:0] ext_o
);
    localparam int NPAD = EXT_W - NARROW_W;
    localparam int WPAD = EXT_W - IN_W;

    always_comb begin
        case ({mode_i.narrow, mode_i.signed_ops})
            2'b11:   ext_o = {{NPAD{raw_i[NARROW_W-1]}}, raw_i[NARROW_W-1:0]};
            2'b10:   ext_o = {{NPAD{1'b0}}, raw_i[NARROW_W-1:0]};
            2'b01:   ext_o = {{WPAD{raw_i[IN_W-1]}}, raw_i};
            default: ext_o = {{WPAD{1'b0}}, raw_i};
        endcase
    end
endmodule

// File: rtl/sat_mac_mult.sv
module sat_mac_mult #(
    parameter int IN_W  = 33,
    parameter int OUT_W = 65
) (
    input  logic signed [IN_W-1:0]  a_i,
    input  logic signed [IN_W-1:0]  b_i,
    output logic signed [OUT_W-1:0] p_o
);
    logic signed [OUT_W-1:0] a_x;
    logic signed [OUT_W-1:0] b_x;

    // Sign-extend before multiplying so the low OUT_W bits are exact
    assign a_x = OUT_W'(a_i);
    assign b_x = OUT_W'(b_i);
    assign p_o = a_x * b_x;
endmodule

// File: rtl/sat_mac_update.sv
module sat_mac_update
    import sat_mac_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int SAT_W  = 48
) (
    input  wr_kind_e                   kind_i,
    input  logic                       sat_i,
    input  logic [2*HALF_W-1:0]        acc_i,
    input  logic signed [2*HALF_W:0]   prod_i,
    input  logic [HALF_W-1:0]          load_i,
    output logic [2*HALF_W-1:0]        acc_o
);
    localparam int ACC_W  = 2 * HALF_W;
    localparam int NSUM_W = HALF_W + 2;
    localparam int WSUM_W = ACC_W + 1;
    localparam int WPAD   = WSUM_W - SAT_W + 1;

    localparam logic signed [NSUM_W-1:0] N_MAX = {3'b000, {(HALF_W-1){1'b1}}};
    localparam logic signed [NSUM_W-1:0] N_MIN = {3'b111, {(HALF_W-1){1'b0}}};
    localparam logic [HALF_W-1:0] LO_MAX  = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] LO_MIN  = {1'b1, {(HALF_W-1){1'b0}}};
    localparam logic [HALF_W-1:0] OV_FLAG = {{(HALF_W-1){1'b0}}, 1'b1};
    localparam logic signed [WSUM_W-1:0] W_MAX = {{WPAD{1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic signed [WSUM_W-1:0] W_MIN = {{WPAD{1'b1}}, {(SAT_W-1){1'b0}}};

    logic [HALF_W-1:0]        acc_hi;
    logic [HALF_W-1:0]        acc_lo;
    logic signed [NSUM_W-1:0] n_sum;
    logic signed [WSUM_W-1:0] w_sum;
    logic [ACC_W-1:0]         n_next;
    logic [ACC_W-1:0]         w_next;

    assign acc_hi = acc_i[ACC_W-1:HALF_W];
    assign acc_lo = acc_i[HALF_W-1:0];

    // Narrow accumulate: lower word as a signed total, with two guard bits
    assign n_sum = $signed({{2{acc_lo[HALF_W-1]}}, acc_lo}) + $signed(prod_i[NSUM_W-1:0]);
    // Wide accumulate: one guard bit, so the clamp sees the exact total
    assign w_sum = $signed({acc_i[ACC_W-1], acc_i}) + prod_i;

    always_comb begin
        if (!sat_i) begin
            n_next = acc_i + prod_i[ACC_W-1:0];
        end else if (n_sum > N_MAX) begin
            n_next = {OV_FLAG, LO_MAX};
        end else if (n_sum < N_MIN) begin
            n_next = {OV_FLAG, LO_MIN};
        end else begin
            n_next = {acc_hi, n_sum[HALF_W-1:0]};
        end
    end

    always_comb begin
        if (!sat_i) begin
            w_next = w_sum[ACC_W-1:0];
        end else if (w_sum > W_MAX) begin
            w_next = W_MAX[ACC_W-1:0];
        end else if (w_sum < W_MIN) begin
            w_next = W_MIN[ACC_W-1:0];
        end else begin
            w_next = w_sum[ACC_W-1:0];
        end
    end

    always_comb begin
        case (kind_i)
            WR_LO_PROD:   acc_o = {acc_hi, prod_i[HALF_W-1:0]};
            WR_FULL_PROD: acc_o = prod_i[ACC_W-1:0];
            WR_ACC_N:     acc_o = n_next;
            WR_ACC_W:     acc_o = w_next;
            WR_CLEAR:     acc_o = '0;
            WR_HI_LOAD:   acc_o = {load_i, acc_lo};
            WR_LO_LOAD:   acc_o = {acc_hi, load_i};
            default:      acc_o = acc_i;
        endcase
    end
endmodule

// File: rtl/sat_mac64.sv
module sat_mac64
    import sat_mac_pkg::*;
#(
    parameter int HALF_W   = 32,
    parameter int NARROW_W = 16,
    parameter int SAT_W    = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic              sat_i,
    input  logic [HALF_W-1:0] opa_i,
    input  logic [HALF_W-1:0] opb_i,
    output logic              done_o,
    output logic [HALF_W-1:0] acc_hi_o,
    output logic [HALF_W-1:0] acc_lo_o
);
    localparam int ACC_W  = 2 * HALF_W;
    localparam int EXT_W  = HALF_W + 1;
    localparam int PROD_W = ACC_W + 1;

    op_ctrl_t                 ctrl;
    logic [1:0][HALF_W-1:0]   raw;
    logic signed [EXT_W-1:0]  ext [2];
    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]         acc_q;
    logic [ACC_W-1:0]         acc_d;
    logic                     done_q;

    assign ctrl   = decode_op(op_i);
    assign raw[0] = opa_i;
    assign raw[1] = opb_i;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        sat_mac_operand #(
            .IN_W     (HALF_W),
            .NARROW_W (NARROW_W),
            .EXT_W    (EXT_W)
        ) u_ext (
            .raw_i  (raw[g]),
            .mode_i (ctrl.mode),
            .ext_o  (ext[g])
        );
    end

    sat_mac_mult #(
        .IN_W  (EXT_W),
        .OUT_W (PROD_W)
    ) u_mult (
        .a_i (ext[0]),
        .b_i (ext[1]),
        .p_o (prod)
    );

    sat_mac_update #(
        .HALF_W (HALF_W),
        .SAT_W  (SAT_W)
    ) u_upd (
        .kind_i (ctrl.kind),
        .sat_i  (sat_i),
        .acc_i  (acc_q),
        .prod_i (prod),
        .load_i (opa_i),
        .acc_o  (acc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start_i;
            if (start_i) begin
                acc_q <= acc_d;
            end
        end
    end

    assign done_o   = done_q;
    assign acc_hi_o = acc_q[ACC_W-1:HALF_W];
    assign acc_lo_o = acc_q[HALF_W-1:0];
endmodule

// File: rtl/sat_mac64_chk.sv
module sat_mac64_chk
    import sat_mac_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int SAT_W  = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [3:0]        op_i,
    input logic              sat_i,
    input logic [HALF_W-1:0] opa_i,
    input logic              done_o,
    input logic [HALF_W-1:0] acc_hi_o,
    input logic [HALF_W-1:0] acc_lo_o
);
    localparam int HI_TOP = SAT_W - 1 - HALF_W;
    localparam logic [HALF_W-1:0] LO_MAX = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] LO_MIN = {1'b1, {(HALF_W-1){1'b0}}};
    localparam logic [HALF_W-1:0] ONE    = {{(HALF_W-1){1'b0}}, 1'b1};

    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    // R1
    always @(posedge clk) begin
        if (rst_seen) begin
            reset_zero_chk: assert (acc_hi_o == '0 && acc_lo_o == '0 && !done_o)
                else $error("accumulator not cleared by reset");
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(acc_hi_o) && $stable(acc_lo_o)));

    // R3 R4
    lo_only_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && (op_i == OP_MUL_LO || op_i == OP_MULU_N || op_i == OP_MULS_N))
        |=> $stable(acc_hi_o));

    // R7
    nsat_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && op_i == OP_MAC_N && sat_i)
        |=> ((acc_hi_o == $past(acc_hi_o)) ||
             (acc_hi_o == ONE && (acc_lo_o == LO_MAX || acc_lo_o == LO_MIN))));

    // R9
    wsat_range_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && op_i == OP_MAC_W && sat_i)
        |=> ((&acc_hi_o[HALF_W-1:HI_TOP]) || !(|acc_hi_o[HALF_W-1:HI_TOP])));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && op_i == OP_CLEAR) |=> (acc_hi_o == '0 && acc_lo_o == '0));

    // R11
    load_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && op_i == OP_LOAD_HI)
        |=> (acc_hi_o == $past(opa_i) && $stable(acc_lo_o)));

    // R11
    load_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && op_i == OP_LOAD_LO)
        |=> (acc_lo_o == $past(opa_i) && $stable(acc_hi_o)));

    // R12
    reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && op_i >= 4'd10)
        |=> ($stable(acc_hi_o) && $stable(acc_lo_o)));
endmodule

bind sat_mac64 sat_mac64_chk #(
    .HALF_W (HALF_W),
    .SAT_W  (SAT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .op_i     (op_i),
    .sat_i    (sat_i),
    .opa_i    (opa_i),
    .done_o   (done_o),
    .acc_hi_o (acc_hi_o),
    .acc_lo_o (acc_lo_o)
);

// File: tb/test_sat_mac64.sv
`timescale 1ns/1ps
module test_sat_mac64;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic        sat_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        done_o;
    logic [31:0] acc_hi_o;
    logic [31:0] acc_lo_o;

    int          vectors = 0;
    int          errors  = 0;
    logic [63:0] acc_m   = '0;
    logic [31:0] rng     = 32'h1F2E3D4C;

    always #2.5 clk = ~clk;

    sat_mac64 i_sat_mac64 (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .op_i     (op_i),
        .sat_i    (sat_i),
        .opa_i    (opa_i),
        .opb_i    (opb_i),
        .done_o   (done_o),
        .acc_hi_o (acc_hi_o),
        .acc_lo_o (acc_lo_o)
    );

    function automatic logic [31:0] step_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Expected accumulator after one operation, from the requirements
    function automatic logic [63:0] model(input logic [3:0] op, input logic s,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [63:0] acc);
        logic [31:0]        lo32;
        longint             p16;
        longint             pw;
        longint             ns;
        logic signed [64:0] ws;
        p16 = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        pw  = longint'($signed(a)) * longint'($signed(b));
        case (op)
            4'd0: begin lo32 = a * b; return {acc[63:32], lo32}; end
            4'd1: begin lo32 = {16'h0, a[15:0]} * {16'h0, b[15:0]}; return {acc[63:32], lo32}; end
            4'd2: return {acc[63:32], p16[31:0]};
            4'd3: return {32'h0, a} * {32'h0, b};
            4'd4: return pw;
            4'd5: begin
                if (!s) return acc + p16;
                ns = longint'($signed(acc[31:0])) + p16;
                if (ns > 64'sd2147483647)  return {32'd1, 32'h7FFFFFFF};
                if (ns < -64'sd2147483648) return {32'd1, 32'h80000000};
                return {acc[63:32], ns[31:0]};
            end
            4'd6: begin
                ws = $signed({acc[63], acc}) + $signed({pw[63], pw});
                if (s && ws > 65'sh00007FFFFFFFFFFF) return 64'h00007FFFFFFFFFFF;
                if (s && ws < -65'sh0000800000000000) return 64'hFFFF800000000000;
                return ws[63:0];
            end
            4'd7: return 64'h0;
            4'd8: return {a, acc[31:0]};
            4'd9: return {acc[63:32], a};
            default: return acc;
        endcase
    endfunction

    task automatic check64(input string req, input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check1(input string req, input logic got, input logic exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Drive one operation, then sample one cycle later
    task automatic apply(input logic [3:0] op, input logic s, input logic [31:0] a,
                         input logic [31:0] b, input string req);
        @(negedge clk);
        start_i = 1'b1; op_i = op; sat_i = s; opa_i = a; opb_i = b;
        acc_m = model(op, s, a, b, acc_m);
        @(negedge clk);
        start_i = 1'b0;
        check1({req, " done"}, done_o, 1'b1);
        check64(req, {acc_hi_o, acc_lo_o}, acc_m);
    endtask

    task automatic load64(input logic [63:0] v);
        apply(4'd8, 1'b0, v[63:32], 32'h0, "R11 load hi");
        apply(4'd9, 1'b0, v[31:0], 32'h0, "R11 load lo");
    endtask

    logic [15:0] nc [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                            16'h8000, 16'h8001, 16'hFFFF, 16'h1234};
    logic [31:0] wc [8] = '{32'h00000000, 32'h00000001, 32'hFFFFFFFF, 32'h7FFFFFFF,
                            32'h80000000, 32'h80000001, 32'h12345678, 32'hDEADBEEF};

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check64("R1 reset acc", {acc_hi_o, acc_lo_o}, 64'h0);
        check1("R1 reset done", done_o, 1'b0);
        rst = 1'b0;

        // R2: idle cycle keeps done low and acc stable
        load64(64'h0123456789ABCDEF);
        @(negedge clk);
        check1("R2 done idle", done_o, 1'b0);
        repeat (3) @(negedge clk);
        check64("R2 hold idle", {acc_hi_o, acc_lo_o}, acc_m);

        // R3, R5: 32-bit corner sweep
        foreach (wc[i]) foreach (wc[j]) begin
            load64(64'hA5A5A5A55A5A5A5A);
            apply(4'd0, 1'b0, wc[i], wc[j], "R3 low product");
            apply(4'd3, 1'b0, wc[i], wc[j], "R5 unsigned full");
            apply(4'd4, 1'b0, wc[i], wc[j], "R5 signed full");
        end

        // R4: 16-bit corner sweep, with noise in the upper halfwords
        foreach (nc[i]) foreach (nc[j]) begin
            apply(4'd8, 1'b0, 32'hC3C3C3C3, 32'h0, "R11 load hi");
            apply(4'd1, 1'b0, {16'hA5C3, nc[i]}, {16'h3C5A, nc[j]}, "R4 unsigned narrow");
            apply(4'd2, 1'b0, {16'h5A3C, nc[i]}, {16'hFFFF, nc[j]}, "R4 signed narrow");
        end

        // R4 explicit: 0xFFFF*0xFFFF signed is 1, unsigned is 0xFFFE0001
        apply(4'd7, 1'b0, 32'h0, 32'h0, "R10 clear");
        apply(4'd2, 1'b0, 32'h1234FFFF, 32'h0000FFFF, "R4 signed narrow");
        check64("R4 signed -1*-1", {acc_hi_o, acc_lo_o}, 64'h0000000000000001);
        apply(4'd1, 1'b0, 32'h1234FFFF, 32'h0000FFFF, "R4 unsigned narrow");
        check64("R4 unsigned ffff^2", {acc_hi_o, acc_lo_o}, 64'h00000000FFFE0001);

        // R6, R7: narrow accumulate sequences from both 32-bit limits
        for (int k = 0; k < 4; k++) begin
            load64(k[0] ? 64'h000000057FFF0000 : 64'hFFFFFFF080010000);
            for (int n = 0; n < 40; n++) begin
                rng = step_rng(rng);
                apply(4'd5, k[1], rng, {rng[15:0], rng[31:16]}, k[1] ? "R7 sat narrow mac" : "R6 wrap narrow mac");
            end
        end

        // R7 explicit: positive and negative saturation with overflow marker
        load64(64'h000000AA7FFFFFF0);
        apply(4'd5, 1'b1, 32'h00000100, 32'h00000100, "R7 sat narrow mac");
        check64("R7 positive limit", {acc_hi_o, acc_lo_o}, 64'h000000017FFFFFFF);
        load64(64'h000000BB80000010);
        apply(4'd5, 1'b1, 32'h00000100, 32'h0000FF00, "R7 sat narrow mac");
        check64("R7 negative limit", {acc_hi_o, acc_lo_o}, 64'h0000000180000000);
        load64(64'h000000CC00000010);
        apply(4'd5, 1'b1, 32'h00000002, 32'h0000FFFD, "R7 sat narrow mac");
        check64("R7 in range keeps hi", {acc_hi_o, acc_lo_o}, 64'h000000CC0000000A);
        load64(64'h00000000FFFFFFFF);
        apply(4'd5, 1'b0, 32'h00000001, 32'h00000001, "R6 wrap narrow mac");
        check64("R6 carry into hi", {acc_hi_o, acc_lo_o}, 64'h0000000100000000);

        // R8, R9: wide accumulate sequences near the 48-bit limits
        for (int k = 0; k < 4; k++) begin
            load64(k[0] ? 64'h00007FFF00000000 : 64'hFFFF800100000000);
            for (int n = 0; n < 40; n++) begin
                rng = step_rng(rng);
                apply(4'd6, k[1], rng, step_rng(rng), k[1] ? "R9 sat wide mac" : "R8 wrap wide mac");
            end
        end

        // R9 explicit clamps and R8 wrap
        load64(64'h00007FFFFFFFFF00);
        apply(4'd6, 1'b1, 32'h00001000, 32'h00001000, "R9 sat wide mac");
        check64("R9 positive clamp", {acc_hi_o, acc_lo_o}, 64'h00007FFFFFFFFFFF);
        load64(64'hFFFF800000000100);
        apply(4'd6, 1'b1, 32'h00001000, 32'hFFFFF000, "R9 sat wide mac");
        check64("R9 negative clamp", {acc_hi_o, acc_lo_o}, 64'hFFFF800000000000);
        load64(64'h7FFFFFFFFFFFFFFF);
        apply(4'd6, 1'b1, 32'h00000001, 32'h00000001, "R9 sat wide mac");
        check64("R9 no 64-bit wrap", {acc_hi_o, acc_lo_o}, 64'h00007FFFFFFFFFFF);
        load64(64'h7FFFFFFFFFFFFFFF);
        apply(4'd6, 1'b0, 32'h00000001, 32'h00000001, "R8 wrap wide mac");
        check64("R8 wraps", {acc_hi_o, acc_lo_o}, 64'h8000000000000000);

        // R10, R11, R12 explicit
        load64(64'hFEDCBA9876543210);
        apply(4'd7, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R10 clear");
        check64("R10 zeroed", {acc_hi_o, acc_lo_o}, 64'h0);
        apply(4'd8, 1'b0, 32'h13579BDF, 32'h0, "R11 load hi");
        apply(4'd9, 1'b0, 32'h2468ACE0, 32'h0, "R11 load lo");
        check64("R11 both halves", {acc_hi_o, acc_lo_o}, 64'h13579BDF2468ACE0);
        for (int c = 10; c < 16; c++) begin
            apply(4'(c), 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, "R12 reserved code");
        end
        check64("R12 unchanged", {acc_hi_o, acc_lo_o}, 64'h13579BDF2468ACE0);

        // Mixed random operation stream
        for (int n = 0; n < 200; n++) begin
            rng = step_rng(rng);
            apply(rng[3:0], rng[4], step_rng(rng), rng, "R2 mixed stream");
        end

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        acc_m = '0;
        check64("R1 reset mid-run", {acc_hi_o, acc_lo_o}, 64'h0);
        check1("R1 reset done", done_o, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule